// File: doc/BRIEF.md
# Operand Forwarding Unit

This block chooses where each source operand of the instruction entering the execute stage of a five-stage in-order pipeline gets its value. There are three candidates. The first is the register-file value already latched for that instruction. The second is the ALU result held by the instruction one stage ahead, in memory access. The third is the final value that the instruction in writeback is committing. When both younger producers write the consumer's register, the nearer one wins. Register zero is never forwarded.

The block also serves the register read in decode. For each decode source, it raises a bypass flag when writeback is committing that same register in the same cycle, so the read returns the new value instead of the stale stored one.

An ALU result can be forwarded, but a loaded value cannot. A value being loaded by the instruction in memory access is not ready in time for execute. In that case the block does not forward it and raises a stall request instead, so the consumer waits one cycle. The selection logic is purely combinational. A clock and a synchronous active-high reset are present only to time the embedded checks.

Top module: `fwd_unit`

## Requirements
- R1: Operand i uses source field `ex_src[i*AW +: AW]` and select field `ex_sel[2*i +: 2]`. Its select is 2'b01 (memory-stage result) when the source is nonzero, equals `mem_dst`, `mem_wen` is 1 and `mem_is_load` is 0.
- R2: An operand select is 2'b10 (writeback value) when the source is nonzero, equals `wb_dst`, `wb_wen` is 1 and R1 does not apply.
- R3: When a source matches both an eligible memory-stage writer and an eligible writeback writer, the select is 2'b01: the younger producer wins.
- R4: A source of register zero always selects 2'b00, never raises its decode bypass and never causes a stall, whatever the producer fields hold.
- R5: A producer whose write enable is 0 is never forwarded from, even when its destination matches.
- R6: `id_wb_bypass[i]` is 1 exactly when decode source `id_src[i*AW +: AW]` is nonzero, equals `wb_dst` and `wb_wen` is 1.
- R7: `load_stall` is 1 exactly when some execute source is nonzero, equals `mem_dst`, `mem_wen` is 1 and `mem_is_load` is 1. Such an operand never selects 2'b01.
- R8: In every other case the select is 2'b00 (register file). The code 2'b11 never appears. Each operand is decided independently of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock used to time the embedded checks |
| rst | input | 1 | Synchronous active-high reset; masks the checks |
| ex_src | input | NUM_SRC*AW | Source register numbers of the instruction in execute |
| id_src | input | NUM_SRC*AW | Source register numbers being read in decode |
| mem_dst | input | AW | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | AW | Destination register of the writeback instruction |
| wb_wen | input | 1 | Writeback instruction writes a register |
| ex_sel | output | 2*NUM_SRC | Per-operand source select: 00 file, 01 memory stage, 10 writeback |
| id_wb_bypass | output | NUM_SRC | Per decode source: take the writeback value around the file |
| load_stall | output | 1 | Load-use hazard: hold the consumer one cycle |

## Verification
The embedded checks watch every cycle for four things. A select must never point at a producer whose enable is off. A matching load must never be forwarded. Register zero must never be forwarded, bypassed or stalled on. The unused code must never appear. These checks cannot show that the value chosen is the right one. Exact matching on a single differing destination bit, the younger-wins choice among several possible producers, and operand independence are shown only by the bench. It compares all outputs against a behavioural model on every cycle, first in directed cases and then over random traffic drawn from a small register range so that matches are frequent.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_MEM = 2'b01,
    SRC_WB  = 2'b10
  } src_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] dst,
  input  logic          wen,
  input  logic          qual,
  output logic          hit
);
  logic src_live;

  assign src_live = (src != '0);
  assign hit      = src_live && wen && qual && (src == dst);
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic          mem_is_load,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wen,
  output src_sel_e      sel,
  output logic          load_hit
);
  logic mem_hit;
  logic wb_hit;

  fwd_match #(.AW(AW)) u_mem (
    .src(src), .dst(mem_dst), .wen(mem_wen), .qual(!mem_is_load), .hit(mem_hit)
  );
  fwd_match #(.AW(AW)) u_wb (
    .src(src), .dst(wb_dst), .wen(wb_wen), .qual(1'b1), .hit(wb_hit)
  );
  fwd_match #(.AW(AW)) u_ld (
    .src(src), .dst(mem_dst), .wen(mem_wen), .qual(mem_is_load), .hit(load_hit)
  );

  always_comb begin
    sel = SRC_RF;
    if (mem_hit)     sel = SRC_MEM;
    else if (wb_hit) sel = SRC_WB;
  end

  p_prio_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_hit && wb_hit) |-> (sel == SRC_MEM));
  p_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (src == '0) |-> (sel == SRC_RF && !load_hit));
  p_mem_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (sel == SRC_MEM) |-> (mem_wen && !mem_is_load));
  p_wb_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (sel == SRC_WB) |-> wb_wen);
  p_load_nofwd_r7: assert property (@(posedge clk) disable iff (rst)
    load_hit |-> (sel != SRC_MEM));
  p_legal_r8: assert property (@(posedge clk) disable iff (rst)
    sel != 2'b11);
endmodule

// File: rtl/fwd_id_bypass.sv
module fwd_id_bypass #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_wen,
  output logic          bypass
);
  fwd_match #(.AW(AW)) u_rf (
    .src(src), .dst(wb_dst), .wen(wb_wen), .qual(1'b1), .hit(bypass)
  );

  p_id_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (src == '0) |-> !bypass);
  p_id_wen_r6: assert property (@(posedge clk) disable iff (rst)
    bypass |-> wb_wen);
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int AW      = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC*AW-1:0] ex_src,
  input  logic [NUM_SRC*AW-1:0] id_src,
  input  logic [AW-1:0]         mem_dst,
  input  logic                  mem_wen,
  input  logic                  mem_is_load,
  input  logic [AW-1:0]         wb_dst,
  input  logic                  wb_wen,
  output logic [2*NUM_SRC-1:0]  ex_sel,
  output logic [NUM_SRC-1:0]    id_wb_bypass,
  output logic                  load_stall
);
  localparam int SEL_W = 2 * NUM_SRC;

  src_sel_e          sel_w [NUM_SRC];
  logic [NUM_SRC-1:0] ld_hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
    fwd_operand_sel #(.AW(AW)) u_sel (
      .clk(clk), .rst(rst),
      .src(ex_src[g*AW +: AW]),
      .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
      .wb_dst(wb_dst), .wb_wen(wb_wen),
      .sel(sel_w[g]), .load_hit(ld_hit[g])
    );
    assign ex_sel[2*g +: 2] = sel_w[g];

    fwd_id_bypass #(.AW(AW)) u_byp (
      .clk(clk), .rst(rst),
      .src(id_src[g*AW +: AW]),
      .wb_dst(wb_dst), .wb_wen(wb_wen),
      .bypass(id_wb_bypass[g])
    );
  end

  assign load_stall = |ld_hit;

  p_stall_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (ex_src == '0) |-> !load_stall);
  p_stall_load_r7: assert property (@(posedge clk) disable iff (rst)
    load_stall |-> (mem_wen && mem_is_load));
  p_sel_width_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(ex_sel) <= SEL_W / 2);
endmodule

// File: tb/test_fwd_unit.sv
module test_fwd_unit;
  localparam int AW = 5;
  localparam int NS = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS*AW-1:0] ex_src = '0, id_src = '0;
  logic [AW-1:0] mem_dst = '0, wb_dst = '0;
  logic          mem_wen = 1'b0, mem_is_load = 1'b0, wb_wen = 1'b0;
  logic [2*NS-1:0] ex_sel;
  logic [NS-1:0] id_wb_bypass;
  logic          load_stall;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  fwd_unit #(.AW(AW), .NUM_SRC(NS)) i_fwd_unit (
    .clk(clk), .rst(rst), .ex_src(ex_src), .id_src(id_src),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
    .wb_dst(wb_dst), .wb_wen(wb_wen),
    .ex_sel(ex_sel), .id_wb_bypass(id_wb_bypass), .load_stall(load_stall)
  );

  function automatic int exp_sel(int s);
    if (s != 0 && mem_wen && !mem_is_load && s == int'(mem_dst)) return 1;
    if (s != 0 && wb_wen && s == int'(wb_dst)) return 2;
    return 0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Compare every output against the behavioural model.
  task automatic check_all(string tag);
    int stall = 0;
    for (int i = 0; i < NS; i++) begin
      int s = int'(ex_src[i*AW +: AW]);
      int d = int'(id_src[i*AW +: AW]);
      chk({tag, " sel"}, int'(ex_sel[2*i +: 2]), exp_sel(s));
      chk({tag, " byp"}, int'(id_wb_bypass[i]),
          (d != 0 && wb_wen && d == int'(wb_dst)) ? 1 : 0);
      if (s != 0 && mem_wen && mem_is_load && s == int'(mem_dst)) stall = 1;
    end
    chk({tag, " stall"}, int'(load_stall), stall);
  endtask

  task automatic drive(int a, int b, int ia, int ib, int md, bit mw, bit ml,
                       int wd, bit ww);
    @(posedge clk); #1;
    ex_src = {AW'(b), AW'(a)};
    id_src = {AW'(ib), AW'(ia)};
    mem_dst = AW'(md); mem_wen = mw; mem_is_load = ml;
    wb_dst = AW'(wd); wb_wen = ww;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_all("R4 reset state");
    chk("R8 reset sel", int'(ex_sel), 0);
    @(posedge clk); #1 rst = 1'b0;

    drive(3, 7, 0, 0, 3, 1, 0, 9, 1);   check_all("R1 mem fwd a");
    chk("R1 a=01", int'(ex_sel[1:0]), 1);
    drive(7, 9, 0, 0, 3, 1, 0, 9, 1);   check_all("R2 wb fwd b");
    chk("R2 b=10", int'(ex_sel[3:2]), 2);
    drive(4, 4, 0, 0, 4, 1, 0, 4, 1);   check_all("R3 both match");
    chk("R3 younger wins", int'(ex_sel), 5);
    drive(0, 0, 0, 0, 0, 1, 1, 0, 1);   check_all("R4 reg zero");
    chk("R4 no stall", int'(load_stall), 0);
    chk("R4 no bypass", int'(id_wb_bypass), 0);
    drive(6, 6, 6, 6, 6, 0, 0, 6, 0);   check_all("R5 enables low");
    chk("R5 sel file", int'(ex_sel), 0);
    drive(0, 0, 8, 2, 0, 0, 0, 8, 1);   check_all("R6 id bypass");
    chk("R6 bit0 only", int'(id_wb_bypass), 1);
    drive(5, 1, 0, 0, 5, 1, 1, 5, 1);   check_all("R7 load use");
    chk("R7 stall", int'(load_stall), 1);
    chk("R7 falls to wb", int'(ex_sel[1:0]), 2);
    drive(2, 5, 0, 0, 5, 1, 1, 9, 0);   check_all("R7 load on b");
    chk("R7 b not mem", int'(ex_sel[3:2]), 0);
    drive(17, 16, 0, 0, 16, 1, 0, 17, 1); check_all("R8 independent");
    chk("R8 a=10 b=01", int'(ex_sel), 6);
    drive(1, 31, 31, 1, 31, 1, 0, 30, 1); check_all("R1 edge reg");

    for (int k = 0; k < 400; k++) begin
      drive($urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 3), $urandom_range(0, 3),
            $urandom_range(0, 3), 1'($urandom), 1'($urandom),
            $urandom_range(0, 3), 1'($urandom));
      check_all("R8 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule